// File: doc/BRIEF.md
# Interlocked Four-Phase Parallel Port

This block is a byte-wide parallel port that talks to an external party over two handshake wires. One wire is an active-low strobe that says "a byte is on the pins". The other is an active-high acknowledge/ready line. A direction input selects which side owns each wire.

In output mode the internal side writes a byte over a valid/ready path. The port drives the byte onto the pins, lowers the strobe a set number of clocks later, and then steps through a full interlock with the receiver's ready line. In input mode the port watches the sender's strobe. It captures the pin byte when the strobe falls, offers the byte on a valid/ready read path, and drives its own ready line low and high again.

Both handshake inputs arrive asynchronously, so each passes through a synchroniser before the sequencers act on it. In input mode, ready is not raised again until the internal side has taken the byte, and this gives back-pressure to the sender.

Top module: `hs_port`

## Requirements
- R1: After reset `avail_n_o` is 1, `accept_o` is 1, `pin_oe_o` is 0 and `rd_valid_o` is 0.
- R2: In output mode (`dir_out_i`=1), a byte taken at a clock edge where `wr_valid_i` and `wr_ready_o` are both 1 appears on `pin_data_o` with `pin_oe_o`=1 after that edge. `avail_n_o` falls exactly SETUP_CYC edges later (default 1). `pin_oe_o` stays 0 until the first byte is taken.
- R3: In output mode, `avail_n_o` stays low and `pin_data_o` stays unchanged until `accept_i` goes low. `avail_n_o` rises at the third clock edge after `accept_i` falls, which covers two synchroniser stages and the state register.
- R4: In output mode, while `accept_i` is low after `avail_n_o` has risen, `wr_ready_o` stays 0 and `avail_n_o` stays 1. `wr_ready_o` returns to 1 at the third edge after `accept_i` rises.
- R5: In input mode (`dir_out_i`=0), the value on `pin_data_i` at the time `avail_n_i` falls is captured. It appears on `rd_data_o` with `rd_valid_o`=1 after the third clock edge following the fall. Later changes on the pins do not alter it.
- R6: In input mode, `accept_o` falls together with the capture. It stays low for as long as `avail_n_i` stays low.
- R7: In input mode, `accept_o` does not rise while `rd_valid_o` is still 1. It rises within a few cycles once the byte has been read and `avail_n_i` is high.
- R8: In input mode, writes are refused (`wr_ready_o`=0), `avail_n_o` is 1 and `pin_oe_o` is 0. In output mode, strobes on `avail_n_i` are ignored: `rd_valid_o` stays 0 and `accept_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_out_i | input | 1 | 1 = output mode, 0 = input mode |
| wr_valid_i | input | 1 | Write byte offered |
| wr_data_i | input | DW | Write byte |
| wr_ready_o | output | 1 | Port takes the write byte |
| rd_valid_o | output | 1 | Captured byte available |
| rd_data_o | output | DW | Captured byte |
| rd_ready_i | input | 1 | Internal side takes the captured byte |
| pin_data_i | input | DW | Port pins, input sense |
| pin_data_o | output | DW | Port pins, drive value |
| pin_oe_o | output | 1 | Pin drive enable |
| avail_n_o | output | 1 | Outgoing strobe, active low (output mode) |
| accept_i | input | 1 | Receiver ready (output mode) |
| avail_n_i | input | 1 | Incoming strobe, active low (input mode) |
| accept_o | output | 1 | Port ready (input mode) |

## Verification
Output transfers use the bytes A5, 00 and FF, and one pair is sent back to back. These show that the pins carry the written value and not a stale or default one, and that the interlock restarts cleanly after the first byte. Input transfers are run twice: once with a consumer that reads at once, and once with a consumer that holds off. This separates the "strobe still low" reason for keeping ready low from the "byte not yet read" reason. The pins are changed after capture to show the byte was latched on the strobe edge. Exact edge counts are checked on the strobe and ready transitions, and these expose any missing or extra synchroniser stage. Finally, each mode is driven with the other mode's stimulus to show that it is ignored.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [1:0] {TX_IDLE, TX_SETUP, TX_STROBE, TX_RECOVER} tx_state_e;
  typedef enum logic {RX_IDLE, RX_HOLD} rx_state_e;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int          W       = 2,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/hs_tx.sv
module hs_tx
  import hs_pkg::*;
#(
  parameter int DW        = 8,
  parameter int SETUP_CYC = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          wr_valid_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          wr_ready_o,
  input  logic          ack_s_i,
  output logic [DW-1:0] data_o,
  output logic          oe_o,
  output logic          avail_n_o
);
  localparam int CW = (SETUP_CYC > 1) ? $clog2(SETUP_CYC) : 1;

  tx_state_e     st_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] data_q;
  logic          oe_q, avail_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= TX_IDLE;
      cnt_q     <= '0;
      data_q    <= '0;
      oe_q      <= 1'b0;
      avail_n_q <= 1'b1;
    end else if (!en_i) begin
      st_q      <= TX_IDLE;
      oe_q      <= 1'b0;
      avail_n_q <= 1'b1;
    end else begin
      case (st_q)
        TX_IDLE: if (wr_valid_i && ack_s_i) begin
          data_q <= wr_data_i;
          oe_q   <= 1'b1;
          cnt_q  <= CW'(SETUP_CYC - 1);
          st_q   <= TX_SETUP;
        end
        TX_SETUP: if (cnt_q == '0) begin
          avail_n_q <= 1'b0;
          st_q      <= TX_STROBE;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        // receiver pulled ready low: byte taken
        TX_STROBE: if (!ack_s_i) begin
          avail_n_q <= 1'b1;
          st_q      <= TX_RECOVER;
        end
        // interlock closes when ready returns high
        TX_RECOVER: if (ack_s_i) st_q <= TX_IDLE;
        default: st_q <= TX_IDLE;
      endcase
    end
  end

  assign wr_ready_o = en_i && (st_q == TX_IDLE) && ack_s_i;
  assign data_o     = data_q;
  assign oe_o       = oe_q;
  assign avail_n_o  = avail_n_q;

  // R2
  tx_data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !avail_n_q |=> (avail_n_q || $stable(data_q)));
  // R2
  tx_strobe_driven_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(avail_n_q) |-> oe_q);
  // R3
  tx_release_on_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(avail_n_q) |-> (!$past(ack_s_i) || !$past(en_i)));
  // R4
  tx_recover_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == TX_RECOVER && !ack_s_i) |=> avail_n_q);
endmodule

// File: rtl/hs_rx.sv
module hs_rx
  import hs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          avail_s_i,
  input  logic [DW-1:0] pin_data_i,
  output logic          rd_valid_o,
  output logic [DW-1:0] rd_data_o,
  input  logic          rd_ready_i,
  output logic          accept_o
);
  rx_state_e     st_q;
  logic          avail_d_q, valid_q, accept_q;
  logic [DW-1:0] data_q;
  logic          strobe_fall;

  assign strobe_fall = avail_d_q && !avail_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= RX_IDLE;
      avail_d_q <= 1'b1;
      valid_q   <= 1'b0;
      accept_q  <= 1'b1;
      data_q    <= '0;
    end else begin
      avail_d_q <= avail_s_i;
      if (valid_q && rd_ready_i) valid_q <= 1'b0;
      if (!en_i) begin
        st_q     <= RX_IDLE;
        valid_q  <= 1'b0;
        accept_q <= 1'b1;
      end else begin
        case (st_q)
          RX_IDLE: if (strobe_fall) begin
            data_q   <= pin_data_i;
            valid_q  <= 1'b1;
            accept_q <= 1'b0;
            st_q     <= RX_HOLD;
          end
          // back-pressure: stay not-ready until byte consumed and strobe released
          RX_HOLD: if (avail_s_i && !valid_q) begin
            accept_q <= 1'b1;
            st_q     <= RX_IDLE;
          end
          default: st_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign rd_valid_o = valid_q;
  assign rd_data_o  = data_q;
  assign accept_o   = accept_q;

  // R5
  rx_capture_drops_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_q) |-> $fell(accept_q));
  // R6
  rx_ready_after_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(accept_q) |-> ($past(avail_s_i) || !$past(en_i)));
  // R7
  rx_ready_after_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(accept_q) |-> (!$past(valid_q) || !$past(en_i)));
endmodule

// File: rtl/hs_port.sv
module hs_port #(
  parameter int DW          = 8,
  parameter int SETUP_CYC   = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dir_out_i,
  input  logic          wr_valid_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          wr_ready_o,
  output logic          rd_valid_o,
  output logic [DW-1:0] rd_data_o,
  input  logic          rd_ready_i,
  input  logic [DW-1:0] pin_data_i,
  output logic [DW-1:0] pin_data_o,
  output logic          pin_oe_o,
  output logic          avail_n_o,
  input  logic          accept_i,
  input  logic          avail_n_i,
  output logic          accept_o
);
  logic [1:0] hs_s;

  hs_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({accept_i, avail_n_i}),
    .q_o   (hs_s)
  );

  hs_tx #(.DW(DW), .SETUP_CYC(SETUP_CYC)) u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (dir_out_i),
    .wr_valid_i(wr_valid_i),
    .wr_data_i (wr_data_i),
    .wr_ready_o(wr_ready_o),
    .ack_s_i   (hs_s[1]),
    .data_o    (pin_data_o),
    .oe_o      (pin_oe_o),
    .avail_n_o (avail_n_o)
  );

  hs_rx #(.DW(DW)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (!dir_out_i),
    .avail_s_i (hs_s[0]),
    .pin_data_i(pin_data_i),
    .rd_valid_o(rd_valid_o),
    .rd_data_o (rd_data_o),
    .rd_ready_i(rd_ready_i),
    .accept_o  (accept_o)
  );
endmodule

// File: tb/sim_hs_port.sv
`timescale 1ns/1ps
module sim_hs_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dir_out = 1'b1;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wr_ready;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic       rd_ready = 1'b0;
  logic [7:0] pin_in = '0;
  logic [7:0] pin_out;
  logic       pin_oe;
  logic       avail_n_out;
  logic       accept_in = 1'b1;
  logic       avail_n_in = 1'b1;
  logic       accept_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  hs_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .dir_out_i(dir_out),
    .wr_valid_i(wr_valid), .wr_data_i(wr_data), .wr_ready_o(wr_ready),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .rd_ready_i(rd_ready),
    .pin_data_i(pin_in), .pin_data_o(pin_out), .pin_oe_o(pin_oe),
    .avail_n_o(avail_n_out), .accept_i(accept_in),
    .avail_n_i(avail_n_in), .accept_o(accept_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 avail_n_o", avail_n_out, 1);
    chk("R1 accept_o", accept_out, 1);
    chk("R1 pin_oe_o", pin_oe, 0);
    chk("R1 rd_valid_o", rd_valid, 0);
  endtask

  task automatic t_tx_byte(input logic [7:0] b);
    int guard = 0;
    while (!wr_ready && guard < 20) begin @(negedge clk); guard++; end
    chk("R4 wr_ready before write", wr_ready, 1);
    wr_valid = 1'b1; wr_data = b;
    @(posedge clk); @(negedge clk);
    wr_valid = 1'b0; wr_data = ~b;
    chk("R2 pin data", pin_out, b);
    chk("R2 pin_oe_o", pin_oe, 1);
    chk("R2 strobe still high", avail_n_out, 1);
    edges(1);
    chk("R2 strobe low after setup", avail_n_out, 0);
    edges(4);
    chk("R3 strobe held", avail_n_out, 0);
    chk("R3 data held", pin_out, b);
    accept_in = 1'b0;
    edges(2);
    chk("R3 strobe low two edges after ack", avail_n_out, 0);
    edges(1);
    chk("R3 strobe released third edge", avail_n_out, 1);
    edges(4);
    chk("R4 no write while ack low", wr_ready, 0);
    chk("R4 strobe stays high", avail_n_out, 1);
    accept_in = 1'b1;
    edges(2);
    chk("R4 wr_ready still low", wr_ready, 0);
    edges(1);
    chk("R4 wr_ready back", wr_ready, 1);
  endtask

  task automatic t_rx_byte(input logic [7:0] b, input bit slow_reader);
    int guard = 0;
    rd_ready = !slow_reader;
    pin_in = b; avail_n_in = 1'b0;
    edges(2);
    chk("R5 not yet captured", rd_valid, 0);
    @(posedge clk); #0.5;
    chk("R5 captured valid", rd_valid, 1);
    chk("R5 captured data", rd_data, b);
    chk("R6 accept_o low", accept_out, 0);
    @(negedge clk);
    pin_in = ~b;
    edges(3);
    chk("R6 accept_o low while strobe low", accept_out, 0);
    if (slow_reader) chk("R5 data held", rd_data, b);
    avail_n_in = 1'b1;
    if (slow_reader) begin
      edges(6);
      chk("R7 accept_o held by unread byte", accept_out, 0);
      chk("R7 rd_valid_o held", rd_valid, 1);
      rd_ready = 1'b1;
      edges(1);
      rd_ready = 1'b0;
    end
    while (!accept_out && guard < 10) begin @(negedge clk); guard++; end
    chk("R7 accept_o returns", accept_out, 1);
    chk("R7 rd_valid_o clear", rd_valid, 0);
    rd_ready = 1'b0;
  endtask

  task automatic t_mode_ignore();
    dir_out = 1'b0;
    edges(2);
    wr_valid = 1'b1; wr_data = 8'h3C;
    edges(4);
    chk("R8 input mode refuses write", wr_ready, 0);
    chk("R8 input mode strobe high", avail_n_out, 1);
    chk("R8 input mode pins undriven", pin_oe, 0);
    wr_valid = 1'b0;
    dir_out = 1'b1;
    edges(3);
    avail_n_in = 1'b0; pin_in = 8'h99;
    edges(6);
    chk("R8 output mode ignores strobe", rd_valid, 0);
    chk("R8 output mode accept_o high", accept_out, 1);
    avail_n_in = 1'b1;
    edges(4);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    edges(3);
    t_reset();
    rst_n = 1'b1;
    edges(3);
    t_reset();
    chk("R2 pins undriven before first write", pin_oe, 0);
    t_tx_byte(8'hA5);
    t_tx_byte(8'h00);
    t_tx_byte(8'hFF);
    t_tx_byte(8'h5A);
    t_mode_ignore();
    dir_out = 1'b0;
    edges(3);
    t_rx_byte(8'hC3, 1'b0);
    t_rx_byte(8'h81, 1'b1);
    t_rx_byte(8'h00, 1'b0);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule